// File: doc/BRIEF.md
# Bitmap Framebuffer Scanout with Host Write Port

This block turns a monochrome bitmap held in a byte-wide synchronous memory into a serial pixel stream for a 256 by 192 display window. An external timing generator supplies a horizontal blank strobe and a vertical blank strobe. The block does not compute addresses in software. A binary scan counter advances once per pixel clock while both strobes are low. Its upper bits address a byte of the bitmap, and its lowest three bits pick one bit of that byte through a bit multiplexer. The chosen bit goes straight to the pixel output.

A host writer reaches the same memory through an address multiplexer. It presents an address and a data byte and raises a request. The write is carried out only while the display is blanked, and a single-cycle grant pulse reports it. Sync pulse generation and the analog colour stage belong to neighbouring blocks.

The memory model is part of the block. It is single-ported, has one cycle of read latency, and is read on every clock, so a new byte is ready as soon as the bit select wraps. This leaves no gap between bytes.

Top module: `fb_scanout`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pix_o` and `host_gnt` are 0. The scan position starts at zero, so the first pixel shown after reset comes from byte 0, bit 7.
- R2: The window is 256 pixels by 192 lines and each line occupies 32 bytes. The pixel at (row, col) comes from byte address row*32 + col/8.
- R3: Within a byte, the pixel at col%8 = k takes data bit 7-k. Bit 7 is the leftmost pixel.
- R4: The scan position advances by one at every clock edge where both blank strobes are low. It holds at an edge where `h_blank` is high and `v_blank` is low, so successive bytes and lines continue without a gap.
- R5: An edge with `v_blank` high returns the scan position to zero, so every frame starts at byte 0.
- R6: `pix_o` shows, two clock edges later, the pixel selected by the strobes sampled at an edge. It is 0 for any edge where `h_blank` or `v_blank` was high.
- R7: A host write is carried out only at an edge where at least one blank strobe is high. A request raised while both strobes are low is held until blanking begins.
- R8: A granted write stores `host_data` at `host_addr`. `host_gnt` is high for exactly one cycle, the cycle after the storing edge, and the host drops `host_req` on seeing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_blank | input | 1 | Horizontal blank strobe, high outside the active part of a line |
| v_blank | input | 1 | Vertical blank strobe, high outside the active lines of a frame |
| host_req | input | 1 | Host write request, held until granted |
| host_addr | input | 13 | Host byte address |
| host_data | input | 8 | Host write byte |
| host_gnt | output | 1 | One-cycle acknowledge of a completed host write |
| pix_o | output | 1 | Serial pixel value, 0 during blanking |

## Verification
Two functions can meet in the same clock: a host request and the last active pixel of a line, which is the edge where scanout hands the memory address over to the host. The bench raises a request exactly on the final active pixel of a line, and also in the middle of an active line. It then checks that the grant only follows an edge at which a blank strobe was sampled high. It also checks that the pixel stream around that edge still matches the model, and that the written byte shows up in later pixels at the position given by R2 and R3.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = $clog2(BYTE_W);

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_ACK  = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic             act;
        logic [SEL_W-1:0] sel;
    } tap_t;

    // Leftmost pixel sits in the most significant bit of the byte.
    function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                      input logic [SEL_W-1:0]  s);
        return b[SEL_W'(BYTE_W-1) - s];
    endfunction

endpackage

// File: rtl/fb_scan_counter.sv
module fb_scan_counter #(
    parameter int unsigned CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             h_blank,
    input  logic             v_blank,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || v_blank) begin
            cnt <= '0;
        end else if (!h_blank) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (!h_blank && !v_blank) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_line_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (h_blank && !v_blank) |=> $stable(cnt));

    assert_frame_restart_R5: assert property (@(posedge clk) disable iff (rst)
        v_blank |=> (cnt == '0));

endmodule

// File: rtl/fb_host_arb.sv
module fb_host_arb
    import fb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blank,
    input  logic req,
    output logic wr_en,
    output logic gnt
);

    arb_state_e state;

    always_comb begin
        wr_en = req && blank && (state == ARB_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
        end else begin
            state <= wr_en ? ARB_ACK : ARB_IDLE;
        end
    end

    assign gnt = (state == ARB_ACK);

    assert_gnt_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        gnt |=> !gnt);

    assert_gnt_after_blank_R7: assert property (@(posedge clk) disable iff (rst)
        gnt |-> $past(blank));

endmodule

// File: rtl/fb_byte_ram.sv
module fb_byte_ram #(
    parameter int unsigned DEPTH  = 6144,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
)(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end

endmodule

// File: rtl/fb_pixel_select.sv
module fb_pixel_select
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] rdata,
    output logic              pix
);

    tap_t tap_q;
    logic bit_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
        end else begin
            tap_q <= '{act: active, sel: sel};
        end
    end

    always_comb begin
        bit_now = tap_q.act && pick_bit(rdata, tap_q.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= 1'b0;
        end else begin
            pix <= bit_now;
        end
    end

    assert_blank_dark_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |=> !pix);

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fb_pkg::*;
#(
    parameter  int unsigned H_PIX   = 256,
    parameter  int unsigned V_LINES = 192,
    localparam int unsigned PIX_CNT = H_PIX * V_LINES,
    localparam int unsigned CNT_W   = $clog2(PIX_CNT + 1),
    localparam int unsigned DEPTH   = PIX_CNT / BYTE_W,
    localparam int unsigned ADDR_W  = CNT_W - SEL_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_blank,
    input  logic              v_blank,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_data,
    output logic              host_gnt,
    output logic              pix_o
);

    logic [CNT_W-1:0]  scan_cnt;
    logic              blanking;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_rdata;

    assign blanking = h_blank || v_blank;

    fb_scan_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .h_blank (h_blank),
        .v_blank (v_blank),
        .cnt     (scan_cnt)
    );

    fb_host_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .blank (blanking),
        .req   (host_req),
        .wr_en (mem_we),
        .gnt   (host_gnt)
    );

    // Address multiplexer: host owns the memory only in its write cycle.
    always_comb begin
        mem_addr = mem_we ? host_addr : scan_cnt[CNT_W-1:SEL_W];
    end

    fb_byte_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (host_data),
        .rdata (mem_rdata)
    );

    fb_pixel_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .active (!blanking),
        .sel    (scan_cnt[SEL_W-1:0]),
        .rdata  (mem_rdata),
        .pix    (pix_o)
    );

endmodule

// File: tb/fb_scanout_test.sv
module fb_scanout_test;

    localparam int CLK_PERIOD = 10;
    localparam int H      = 256;
    localparam int V      = 192;
    localparam int HBL    = 8;
    localparam int VBL    = 2 * (H + HBL);
    localparam int NBYTES = H * V / 8;
    localparam int BPL    = H / 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_blank = 1'b1;
    logic        v_blank = 1'b1;
    logic        host_req = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        host_gnt;
    logic        pix_o;

    fb_scanout uut (
        .clk       (clk),
        .rst       (rst),
        .h_blank   (h_blank),
        .v_blank   (v_blank),
        .host_req  (host_req),
        .host_addr (host_addr),
        .host_data (host_data),
        .host_gnt  (host_gnt),
        .pix_o     (pix_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        blank;
        logic [12:0] addr;
        logic [2:0]  col_lo;
        logic        frame2;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] model [NBYTES];
    int checks = 0;
    int errors = 0;
    bit fill_done = 0;
    bit gen_done  = 0;
    bit mon_on    = 0;
    int cur_row = -1;
    int cur_col = -1;
    bit cur_act = 0;
    bit last_gnt = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37) ^ (a >> 4) ^ 8'h5a);
    endfunction

    // Driver: one call per clock, pushes the expected pixel position.
    task automatic drive_cycle(input bit hb, input bit vb, input int row,
                               input int col, input bit f2);
        item_t it;
        @(negedge clk);
        h_blank = hb;
        v_blank = vb;
        cur_row = row;
        cur_col = col;
        cur_act = !(hb || vb);
        it.blank  = hb || vb;
        it.addr   = 13'(row * BPL + col / 8);
        it.col_lo = 3'(col % 8);
        it.frame2 = f2;
        exp_q.push_back(it);
    endtask

    task automatic run_frame(input bit f2);
        for (int r = 0; r < V; r++) begin
            for (int c = 0; c < H; c++) drive_cycle(1'b0, 1'b0, r, c, f2);
            for (int c = 0; c < HBL; c++) drive_cycle(1'b1, 1'b0, r, H, f2);
        end
        for (int k = 0; k < VBL; k++) drive_cycle(1'b1, 1'b1, -1, -1, f2);
    endtask

    // Host writer: holds the request until the grant pulse.
    task automatic host_write(input int a, input logic [7:0] d, input string rq);
        int waited;
        waited = 0;
        @(negedge clk);
        host_req  = 1'b1;
        host_addr = 13'(a);
        host_data = d;
        do begin
            @(negedge clk);
            waited++;
        end while (!host_gnt && waited < 4 * (H + HBL));
        chk(host_gnt == 1'b1, rq, host_gnt, 1);
        model[a]  = d;
        host_req  = 1'b0;
    endtask

    task automatic wait_pos(input int row, input int col);
        do begin
            @(posedge clk);
            #1;
        end while (!(cur_row == row && cur_col == col && cur_act));
    endtask

    // Monitor: pops expected items and compares the stream, watches the grant.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (mon_on) begin
                if (host_gnt) begin
                    chk(h_blank || v_blank, "R7 grant follows blanked edge",
                        int'(h_blank || v_blank), 1);
                    chk(!last_gnt, "R8 grant single cycle", int'(last_gnt), 0);
                end
                last_gnt = host_gnt;
                if (exp_q.size() >= 2) begin
                    item_t it;
                    logic  e;
                    it = exp_q.pop_front();
                    if (it.blank) begin
                        e = 1'b0;
                        chk(pix_o == e, "R6 blank output zero", pix_o, e);
                    end else begin
                        e = model[it.addr][3'd7 - it.col_lo];
                        if (it.frame2)
                            chk(pix_o == e, "R5 R2 R3 frame restart pixel", pix_o, e);
                        else
                            chk(pix_o == e, "R2 R3 R4 scan pixel", pix_o, e);
                    end
                end
            end
        end
    end

    // Timing generator.
    initial begin
        repeat (5) @(negedge clk);
        chk(pix_o == 1'b0, "R1 pix_o in reset", pix_o, 0);
        chk(host_gnt == 1'b0, "R1 host_gnt in reset", host_gnt, 0);
        rst = 1'b0;
        mon_on = 1;
        @(negedge clk);
        chk(pix_o == 1'b0, "R1 pix_o after reset", pix_o, 0);
        chk(host_gnt == 1'b0, "R1 host_gnt after reset", host_gnt, 0);
        while (!fill_done) drive_cycle(1'b1, 1'b1, -1, -1, 1'b0);
        run_frame(1'b0);
        run_frame(1'b1);
        repeat (4) @(negedge clk);
        gen_done = 1;
    end

    // Host stimulus.
    initial begin
        @(negedge clk);
        while (rst) @(negedge clk);
        for (int a = 0; a < NBYTES; a++) host_write(a, pattern(a), "R8 fill write");
        fill_done = 1;
        wait_pos(3, 100);
        host_write(50 * BPL + 5, 8'ha5, "R7 request held during active line");
        wait_pos(10, H - 2);
        host_write(12 * BPL + 31, 8'h0f, "R7 request on last active pixel");
        wait_pos(20, 40);
        host_write(0, 8'h81, "R8 write byte 0 for next frame");
        wait_pos(100, 7);
        host_write(NBYTES - 1, 8'h3c, "R8 write last byte");
    end

    initial begin
        wait (gen_done);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule